// File: doc/BRIEF.md
# Occupancy-Driven Clock Scaling Controller

This block sits between a processing core and the tile interface that feeds it. Each stream enters or leaves the core through a single-entry buffer in a core port, and each port reports a stall flag while a transfer is blocked. A stalled input means the core drains its input too slowly. A stalled output means the core produces faster than the interconnect takes its results. Over a fixed window of interconnect cycles the controller counts both kinds of stall. At the end of each window it moves the core one step faster, one step slower, or holds it.

The core runs at one of four power-of-two fractions of the interconnect clock: full, one half, one quarter or one eighth. Each rate has a paired supply-level code. The rate is delivered as a single-cycle enable pulse, so no derived clock net is needed. Voltage and divider changes are sequenced so that the supply is never below what the current rate needs. When the core speeds up, the supply rises first. When it slows down, the supply drops last. A fixed settle interval separates the two moves.

Top module: `occ_clk_scaler`

## Requirements
- R1: After synchronous reset, `div_sel` is 0 (full rate), `vlevel` is 3 (highest supply), and `core_en` is high in every cycle.
- R2: Stalls are counted over consecutive windows of WINDOW (64) cycles, starting with the first cycle after reset. The verdict is taken at the last cycle of each window and includes that cycle's stall flags. The counts then restart from zero.
- R3: If a window holds more than UP_TH (16) input stalls and no more than DN_TH (16) output stalls, the rate moves one step faster (`div_sel` minus 1). A window with exactly UP_TH input stalls causes no change.
- R4: If a window holds more than DN_TH output stalls and no more than UP_TH input stalls, the rate moves one step slower (`div_sel` plus 1).
- R5: If both counts exceed their thresholds in the same window, the rate and supply code stay unchanged.
- R6: `div_sel` saturates at 0 and at 3. It never wraps, and it changes by at most one step at a time.
- R7: On a step faster, `vlevel` rises by one at the verdict edge. `div_sel` then falls by one SETTLE (8) cycles later, and `vlevel` is stable in that cycle.
- R8: On a step slower, `div_sel` rises by one at the verdict edge. `vlevel` then falls by one SETTLE cycles later, and `div_sel` is stable in that cycle.
- R9: `vlevel` is never below 3 minus `div_sel`, which is the code paired with the current rate.
- R10: `div_sel` code k selects a rate of 1/2^k. `core_en` is high exactly in the cycles whose count since reset is a multiple of 2^k, so it is never high in two consecutive cycles at a constant k of 1 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interconnect clock |
| rst | input | 1 | Synchronous active-high reset |
| in_blocked | input | 1 | Input core port stalled this cycle |
| out_blocked | input | 1 | Output core port stalled this cycle |
| core_en | output | 1 | Single-cycle enable pulse at the selected rate |
| div_sel | output | 2 | Rate code: 0 full, 1 half, 2 quarter, 3 eighth |
| vlevel | output | 2 | Supply-level code, 3 highest |

## Verification
Two functions can meet in one verdict cycle. The input and output stall counts can both cross their thresholds in the same window, and a step request can arrive when the rate is already at a limit. The bench holds both ports stalled for whole windows at the slowest and at the fastest setting. It also keeps requesting further steps after a limit is reached. A behavioural reference model judges every cycle, and directed checks confirm the literal rate and supply codes. Threshold edges are driven aligned to the window, with exactly UP_TH and UP_TH+1 stalls.

// File: rtl/clkscale_pkg.sv
package clkscale_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_FASTER = 2'd1,
        STEP_SLOWER = 2'd2
    } step_e;

    typedef struct packed {
        logic  valid;
        step_e step;
    } verdict_t;

    typedef enum logic [1:0] {
        SEQ_IDLE       = 2'd0,
        SEQ_RAISE_WAIT = 2'd1,
        SEQ_LOWER_WAIT = 2'd2
    } seq_e;

    function automatic step_e pick_step(input logic fast_req, input logic slow_req);
        if (fast_req && !slow_req)      return STEP_FASTER;
        else if (slow_req && !fast_req) return STEP_SLOWER;
        else                            return STEP_HOLD;
    endfunction

endpackage

// File: rtl/stall_window.sv
module stall_window
    import clkscale_pkg::*;
#(
    parameter int WINDOW = 64,
    parameter int UP_TH  = 16,
    parameter int DN_TH  = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_blocked,
    input  logic     out_blocked,
    output verdict_t verdict
);
    localparam int WW = $clog2(WINDOW);
    localparam int CW = $clog2(WINDOW + 1);

    logic [WW-1:0] win_q;
    logic [CW-1:0] in_q, out_q;
    logic [CW-1:0] in_tot, out_tot;
    logic          last_cyc;

    assign in_tot   = in_q + CW'(in_blocked);
    assign out_tot  = out_q + CW'(out_blocked);
    assign last_cyc = (win_q == WW'(WINDOW - 1));

    always_comb begin
        verdict.valid = last_cyc;
        verdict.step  = pick_step(in_tot > CW'(UP_TH), out_tot > CW'(DN_TH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            in_q  <= '0;
            out_q <= '0;
        end else if (last_cyc) begin
            win_q <= '0;
            in_q  <= '0;
            out_q <= '0;
        end else begin
            win_q <= win_q + 1'b1;
            in_q  <= in_tot;
            out_q <= out_tot;
        end
    end

    // Counts restart with each window
    assert_window_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (win_q == '0) |-> (in_q == '0 && out_q == '0));

    // A count cannot exceed the cycles elapsed in the window
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (in_q <= CW'(win_q)) && (out_q <= CW'(win_q)));

endmodule

// File: rtl/rate_sequencer.sv
module rate_sequencer
    import clkscale_pkg::*;
#(
    parameter int NUM_RATES = 4,
    parameter int SETTLE    = 8,
    localparam int RW = $clog2(NUM_RATES)
) (
    input  logic          clk,
    input  logic          rst,
    input  verdict_t      verdict,
    output logic [RW-1:0] div_idx,
    output logic [RW-1:0] volt_idx
);
    localparam int TW = $clog2(SETTLE);
    localparam logic [RW-1:0] SLOWEST = RW'(NUM_RATES - 1);

    seq_e          st_q;
    logic [TW-1:0] tmr_q;
    logic [RW-1:0] div_q, volt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            tmr_q  <= '0;
            div_q  <= '0;
            volt_q <= '0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    if (verdict.valid) begin
                        if (verdict.step == STEP_FASTER && div_q != '0) begin
                            volt_q <= div_q - 1'b1;
                            tmr_q  <= TW'(SETTLE - 1);
                            st_q   <= SEQ_RAISE_WAIT;
                        end else if (verdict.step == STEP_SLOWER && div_q != SLOWEST) begin
                            div_q  <= div_q + 1'b1;
                            tmr_q  <= TW'(SETTLE - 1);
                            st_q   <= SEQ_LOWER_WAIT;
                        end
                    end
                end
                SEQ_RAISE_WAIT: begin
                    if (tmr_q == '0) begin
                        div_q <= volt_q;
                        st_q  <= SEQ_IDLE;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                SEQ_LOWER_WAIT: begin
                    if (tmr_q == '0) begin
                        volt_q <= div_q;
                        st_q   <= SEQ_IDLE;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    assign div_idx  = div_q;
    assign volt_idx = volt_q;

    // Supply index never slower than the divider index
    assert_volt_covers_R9: assert property (@(posedge clk) disable iff (rst)
        volt_q <= div_q);

    // Divider moves by single steps and never wraps
    assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_q) |-> ((int'(div_q) == int'($past(div_q)) + 1) ||
                             (int'(div_q) == int'($past(div_q)) - 1)));

    // Speeding up: supply already raised when divider drops
    assert_raise_first_R7: assert property (@(posedge clk) disable iff (rst)
        (div_q < $past(div_q)) |-> $stable(volt_q));

    // Slowing down: divider already moved when supply drops
    assert_lower_last_R8: assert property (@(posedge clk) disable iff (rst)
        (volt_q > $past(volt_q)) |-> $stable(div_q));

endmodule

// File: rtl/enable_divider.sv
module enable_divider #(
    parameter int NUM_RATES = 4,
    localparam int RW = $clog2(NUM_RATES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] sel,
    output logic          en
);
    localparam int CW = (NUM_RATES > 1) ? NUM_RATES - 1 : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] mask;

    assign mask = (CW'(1) << sel) - CW'(1);
    assign en   = ((cnt_q & mask) == '0);

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    // At any reduced rate two pulses never touch
    assert_pulse_gap_R10: assert property (@(posedge clk) disable iff (rst)
        (en && sel != '0) |=> (!en || sel != $past(sel)));

endmodule

// File: rtl/occ_clk_scaler.sv
module occ_clk_scaler
    import clkscale_pkg::*;
#(
    parameter int NUM_RATES = 4,
    parameter int WINDOW    = 64,
    parameter int UP_TH     = 16,
    parameter int DN_TH     = 16,
    parameter int SETTLE    = 8,
    localparam int RW = $clog2(NUM_RATES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_blocked,
    input  logic          out_blocked,
    output logic          core_en,
    output logic [RW-1:0] div_sel,
    output logic [RW-1:0] vlevel
);
    verdict_t      verdict;
    logic [RW-1:0] div_idx, volt_idx;

    stall_window #(.WINDOW(WINDOW), .UP_TH(UP_TH), .DN_TH(DN_TH)) u_window (
        .clk         (clk),
        .rst         (rst),
        .in_blocked  (in_blocked),
        .out_blocked (out_blocked),
        .verdict     (verdict)
    );

    rate_sequencer #(.NUM_RATES(NUM_RATES), .SETTLE(SETTLE)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .verdict  (verdict),
        .div_idx  (div_idx),
        .volt_idx (volt_idx)
    );

    enable_divider #(.NUM_RATES(NUM_RATES)) u_div (
        .clk (clk),
        .rst (rst),
        .sel (div_idx),
        .en  (core_en)
    );

    assign div_sel = div_idx;
    assign vlevel  = RW'(NUM_RATES - 1) - volt_idx;

    // Port-level pairing of supply code and rate
    assert_vlevel_floor_R9: assert property (@(posedge clk) disable iff (rst)
        vlevel >= (RW'(NUM_RATES - 1) - div_sel));

    // Full rate means an enable in every cycle
    assert_full_rate_R10: assert property (@(posedge clk) disable iff (rst)
        (div_sel == '0) |-> core_en);

endmodule

// File: tb/occ_clk_scaler_bench.sv
`timescale 1ns/1ps
module occ_clk_scaler_bench;
    localparam int W  = 64;
    localparam int UT = 16;
    localparam int DT = 16;
    localparam int S  = 8;
    localparam int NR = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_blocked = 1'b0;
    logic       out_blocked = 1'b0;
    logic       core_en;
    logic [1:0] div_sel, vlevel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    occ_clk_scaler u_occ_clk_scaler (
        .clk(clk), .rst(rst), .in_blocked(in_blocked), .out_blocked(out_blocked),
        .core_en(core_en), .div_sel(div_sel), .vlevel(vlevel)
    );

    // Behavioural reference model
    int  m_cyc, m_wc, m_ic, m_oc, m_div, m_v, m_tmr;
    bit  m_busy, m_up, started;

    always @(posedge clk) begin
        if (rst) begin
            m_cyc = 0; m_wc = 0; m_ic = 0; m_oc = 0;
            m_div = 0; m_v = 0; m_tmr = 0; m_busy = 0; m_up = 0;
            started = 1;
        end else begin
            bit go_up, go_dn;
            int it, ot;
            it = m_ic + int'(in_blocked);
            ot = m_oc + int'(out_blocked);
            go_up = (m_wc == W-1) && (it > UT) && !(ot > DT);
            go_dn = (m_wc == W-1) && (ot > DT) && !(it > UT);
            if (m_busy) begin
                if (m_tmr == 0) begin
                    if (m_up) m_div = m_v; else m_v = m_div;
                    m_busy = 0;
                end else m_tmr--;
            end else if (go_up && m_div > 0) begin
                m_v = m_div - 1; m_busy = 1; m_up = 1; m_tmr = S - 1;
            end else if (go_dn && m_div < NR-1) begin
                m_div = m_div + 1; m_busy = 1; m_up = 0; m_tmr = S - 1;
            end
            if (m_wc == W-1) begin m_wc = 0; m_ic = 0; m_oc = 0; end
            else begin m_wc++; m_ic = it; m_oc = ot; end
            m_cyc++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R2 R3 R4 R6 R7 R8 div_sel", int'(div_sel), m_div);
            chk("R7 R8 R9 vlevel", int'(vlevel), 3 - m_v);
            chk("R10 core_en", int'(core_en), int'((m_cyc % (1 << m_div)) == 0));
        end
    end

    task automatic cycles(input int n, input bit i, input bit o);
        for (int k = 0; k < n; k++) begin
            in_blocked = i; out_blocked = o;
            @(negedge clk);
        end
        in_blocked = 0; out_blocked = 0;
    endtask

    // One aligned window with the first kin/kout cycles stalled
    task automatic aligned_window(input int kin, input int kout);
        while (m_wc != 0) @(negedge clk);
        for (int k = 0; k < W; k++) begin
            in_blocked = (k < kin); out_blocked = (k < kout);
            @(negedge clk);
        end
        in_blocked = 0; out_blocked = 0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 div_sel after reset", int'(div_sel), 0);
        chk("R1 vlevel after reset", int'(vlevel), 3);
        chk("R1 core_en after reset", int'(core_en), 1);

        // Step slower, single step ordering
        aligned_window(0, DT + 1);
        chk("R8 div_sel at verdict", int'(div_sel), 1);
        chk("R8 vlevel held at verdict", int'(vlevel), 3);
        repeat (S - 1) @(negedge clk);
        chk("R8 vlevel before settle", int'(vlevel), 3);
        @(negedge clk);
        chk("R8 vlevel after settle", int'(vlevel), 2);

        // Drive to slowest and keep requesting
        cycles(7 * W, 1'b0, 1'b1);
        chk("R6 slowest div_sel", int'(div_sel), 3);
        chk("R6 slowest vlevel", int'(vlevel), 0);

        // Both ports stalled at the slow limit
        cycles(3 * W, 1'b1, 1'b1);
        chk("R5 hold div_sel", int'(div_sel), 3);
        chk("R5 hold vlevel", int'(vlevel), 0);

        // Threshold boundary on the input side
        aligned_window(UT, 0);
        aligned_window(UT, 0);
        chk("R3 exactly threshold no step", int'(div_sel), 3);
        aligned_window(UT + 1, 0);
        chk("R7 vlevel raised at verdict", int'(vlevel), 1);
        chk("R7 div_sel held at verdict", int'(div_sel), 3);
        repeat (S - 1) @(negedge clk);
        chk("R7 div_sel before settle", int'(div_sel), 3);
        @(negedge clk);
        chk("R7 div_sel after settle", int'(div_sel), 2);

        // Drive to fastest and keep requesting
        cycles(6 * W, 1'b1, 1'b0);
        chk("R6 fastest div_sel", int'(div_sel), 0);
        chk("R6 fastest vlevel", int'(vlevel), 3);
        cycles(2 * W, 1'b1, 1'b1);
        chk("R5 hold at fastest", int'(div_sel), 0);

        // Random densities per window
        for (int w = 0; w < 40; w++) begin
            int pin, pout;
            pin  = $urandom_range(0, 3) * 15;
            pout = $urandom_range(0, 3) * 15;
            for (int k = 0; k < W; k++) begin
                in_blocked  = ($urandom_range(0, 99) < pin);
                out_blocked = ($urandom_range(0, 99) < pout);
                @(negedge clk);
            end
        end
        in_blocked = 0; out_blocked = 0;
        repeat (2 * S) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule